// File: doc/BRIEF.md
# Paged Program-Space Address Decoder

This block steers each program-space access of a processor core to the memory that serves it. An access is a 7-bit page extension value, a 16-bit in-page address and a write strobe. Four mode inputs shape the decode: an overlay enable for the lower half-page, a microcomputer/microprocessor select for the upper half-page, an external-I/O mode input, and a boot-ROM enable bit. The block answers one cycle later with a one-hot target select, the physical page and offset, and a violation flag.

Only pages 0 to 3 are internal. Every page from 4 to 127 lands on one of the four external pages. When the boot ROM is active it takes over the top 8K words of page 0. The ROM itself fills the top 2K of that block and the rest of the block has no target. Processor writes into shared program RAM are refused. Writes from a DMA master are let through.

The block also holds the boot-ROM enable bit. That bit is loaded from a strap pin on the first clock after reset, and software can later clear it but not set it. The block also registers the data-space scratch RAM enable.

Top module: `prog_space_decoder`

## Requirements
- R1: In the lower half of any page (address bit 15 = 0), an access goes to local RAM when ovly_i=1 and to the external bus when ovly_i=0, for every page value.
- R2: In the upper half of any page (address bit 15 = 1) with mpmc_i=1, every access goes to the external bus.
- R3: In the upper half with mpmc_i=0, pages 0–3 select shared program RAM and pages 4–127 select the external bus, except where R5 or R7 apply.
- R4: phys_page_o equals the page when the page is below 4, and 4 + (page mod 4) otherwise. offset_o equals the request address.
- R5: The boot ROM is active only when xio_i=1 and romen_o=1. While it is active, an upper-half page-0 access at 0xF800–0xFFFF selects the ROM and one at 0xE000–0xF7FF selects no target. While it is inactive, those addresses follow R3.
- R6: romen_o takes the value of gpio0_i on the first clock after reset. A configuration write with bit 7 = 0 clears it. A write with bit 7 = 1 leaves it unchanged.
- R7: A write (wr_i=1, dma_i=0) that would select shared RAM instead selects no target and raises viol_o. With dma_i=1 the same write selects shared RAM and viol_o stays low.
- R8: The results of a request appear one clock after the request is presented. Exactly one of the five selects is high for a valid request, and all five are low when no request was presented.
- R9: sram_en_o is 0 after reset and equals drom_i as it was one clock earlier.
- R10: While reset is asserted, all selects, viol_o, valid_o and sram_en_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| page_i | input | 7 | Page extension value |
| addr_i | input | 16 | In-page address |
| wr_i | input | 1 | 1 = write, 0 = read/fetch |
| dma_i | input | 1 | Request comes from the DMA master |
| ovly_i | input | 1 | Lower-half overlay enable |
| mpmc_i | input | 1 | Upper half forced external when 1 |
| xio_i | input | 1 | External-I/O mode; gates the boot ROM |
| gpio0_i | input | 1 | Strap sampled to load the ROM enable after reset |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 8 | Configuration write data; bit 7 = ROM enable |
| drom_i | input | 1 | Data-space scratch RAM enable request |
| sel_none_o | output | 1 | No target |
| sel_local_o | output | 1 | Local RAM select |
| sel_shared_o | output | 1 | Shared program RAM select |
| sel_rom_o | output | 1 | Boot ROM select |
| sel_ext_o | output | 1 | External bus select |
| phys_page_o | output | 3 | Physical page |
| offset_o | output | 16 | Offset within the page |
| viol_o | output | 1 | Refused write to shared RAM |
| valid_o | output | 1 | Registered request valid |
| romen_o | output | 1 | Current ROM enable bit |
| sram_en_o | output | 1 | Data-space scratch RAM enable |

## Verification
If the registered target were stale or corrupt, the selects would disagree with the bench's arithmetic model on the very next request. That mismatch is caught within one clock. The sweep also crosses every page with the half-page and ROM-hole boundaries, so an error in the page aliasing shows up in phys_page_o on the first aliased page. A ROM enable bit that loads wrongly at reset, or that can be set again by software, changes romen_o at once. It also moves the page-0 accesses at 0xE000–0xFFFF between the ROM, no target and shared RAM in the next full sweep.

// File: rtl/psd_pkg.sv
package psd_pkg;
  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_LOCAL  = 3'd1,
    TGT_SHARED = 3'd2,
    TGT_ROM    = 3'd3,
    TGT_EXT    = 3'd4
  } tgt_e;
  localparam int unsigned N_TGT = 5;
endpackage

// File: rtl/psd_route.sv
module psd_route
  import psd_pkg::*;
#(
  parameter int unsigned PAGE_W     = 7,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned INT_PAGES  = 4,
  parameter int unsigned ROM_WORDS  = 2048,
  parameter int unsigned HOLE_WORDS = 8192,
  localparam int unsigned IDX_W     = $clog2(INT_PAGES),
  localparam int unsigned PP_W      = IDX_W + 1
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              dma_i,
  input  logic              ovly_i,
  input  logic              mpmc_i,
  input  logic              rom_act_i,
  output tgt_e              tgt_o,
  output logic              viol_o,
  output logic [PP_W-1:0]   phys_page_o
);
  localparam logic [ADDR_W-1:0] HOLE_BASE = ADDR_W'((1 << ADDR_W) - HOLE_WORDS);
  localparam logic [ADDR_W-1:0] ROM_BASE  = ADDR_W'((1 << ADDR_W) - ROM_WORDS);

  logic is_int, upper, in_hole, in_rom;

  assign is_int  = page_i < PAGE_W'(INT_PAGES);
  assign upper   = addr_i[ADDR_W-1];
  assign in_hole = (page_i == '0) && (addr_i >= HOLE_BASE);
  assign in_rom  = addr_i >= ROM_BASE;
  // pages beyond the internal set alias onto the external set
  assign phys_page_o = {~is_int, page_i[IDX_W-1:0]};

  always_comb begin
    tgt_o  = TGT_NONE;
    viol_o = 1'b0;
    if (!upper) begin
      tgt_o = ovly_i ? TGT_LOCAL : TGT_EXT;
    end else if (mpmc_i || !is_int) begin
      tgt_o = TGT_EXT;
    end else if (rom_act_i && in_hole) begin
      tgt_o = in_rom ? TGT_ROM : TGT_NONE;
    end else if (wr_i && !dma_i) begin
      tgt_o  = TGT_NONE;
      viol_o = 1'b1;
    end else begin
      tgt_o = TGT_SHARED;
    end
  end
endmodule

// File: rtl/psd_ctrl.sv
module psd_ctrl #(
  parameter int unsigned CFG_W     = 8,
  parameter int unsigned ROMEN_BIT = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gpio0_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             drom_i,
  output logic             romen_o,
  output logic             sram_en_o
);
  logic init_q, romen_q, sram_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q  <= 1'b1;
      romen_q <= 1'b0;
      sram_q  <= 1'b0;
    end else begin
      init_q <= 1'b0;
      sram_q <= drom_i;
      if (init_q)
        romen_q <= gpio0_i;
      else if (cfg_we_i && !cfg_wdata_i[ROMEN_BIT])
        romen_q <= 1'b0;  // software may only clear
    end
  end

  assign romen_o   = romen_q;
  assign sram_en_o = sram_q;

  AST_ROMEN_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(romen_q) |-> $past(init_q));  // R6
  AST_SRAM_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_en_o |-> $past(drom_i));  // R9
endmodule

// File: rtl/prog_space_decoder.sv
module prog_space_decoder
  import psd_pkg::*;
#(
  parameter int unsigned PAGE_W     = 7,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned INT_PAGES  = 4,
  parameter int unsigned ROM_WORDS  = 2048,
  parameter int unsigned HOLE_WORDS = 8192,
  parameter int unsigned CFG_W      = 8,
  parameter int unsigned ROMEN_BIT  = 7,
  localparam int unsigned PP_W      = $clog2(INT_PAGES) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              dma_i,
  input  logic              ovly_i,
  input  logic              mpmc_i,
  input  logic              xio_i,
  input  logic              gpio0_i,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              drom_i,
  output logic              sel_none_o,
  output logic              sel_local_o,
  output logic              sel_shared_o,
  output logic              sel_rom_o,
  output logic              sel_ext_o,
  output logic [PP_W-1:0]   phys_page_o,
  output logic [ADDR_W-1:0] offset_o,
  output logic              viol_o,
  output logic              valid_o,
  output logic              romen_o,
  output logic              sram_en_o
);
  tgt_e            tgt_d, tgt_q;
  logic            viol_d, viol_q, valid_q;
  logic [PP_W-1:0] pp_d, pp_q;
  logic [ADDR_W-1:0] off_q;
  logic [N_TGT-1:0]  sel_vec;
  logic            romen;

  psd_ctrl #(.CFG_W(CFG_W), .ROMEN_BIT(ROMEN_BIT)) u_ctrl (
    .clk_i, .rst_ni, .gpio0_i, .cfg_we_i, .cfg_wdata_i, .drom_i,
    .romen_o(romen), .sram_en_o
  );

  psd_route #(
    .PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .INT_PAGES(INT_PAGES),
    .ROM_WORDS(ROM_WORDS), .HOLE_WORDS(HOLE_WORDS)
  ) u_route (
    .page_i, .addr_i, .wr_i, .dma_i, .ovly_i, .mpmc_i,
    .rom_act_i(xio_i & romen),
    .tgt_o(tgt_d), .viol_o(viol_d), .phys_page_o(pp_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tgt_q   <= TGT_NONE;
      viol_q  <= 1'b0;
      pp_q    <= '0;
      off_q   <= '0;
    end else begin
      valid_q <= req_valid_i;
      tgt_q   <= tgt_d;
      viol_q  <= req_valid_i & viol_d;
      pp_q    <= pp_d;
      off_q   <= addr_i;
    end
  end

  for (genvar k = 0; k < N_TGT; k++) begin : g_sel
    assign sel_vec[k] = valid_q && (tgt_q == tgt_e'(k));
  end

  assign sel_none_o   = sel_vec[TGT_NONE];
  assign sel_local_o  = sel_vec[TGT_LOCAL];
  assign sel_shared_o = sel_vec[TGT_SHARED];
  assign sel_rom_o    = sel_vec[TGT_ROM];
  assign sel_ext_o    = sel_vec[TGT_EXT];
  assign phys_page_o  = pp_q;
  assign offset_o     = off_q;
  assign viol_o       = viol_q;
  assign valid_o      = valid_q;
  assign romen_o      = romen;

  AST_ONE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $onehot(sel_vec));  // R8
  AST_IDLE_NO_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (sel_vec == '0));  // R8
  AST_VIOL_NO_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> sel_none_o);  // R7
  AST_ROM_NEEDS_XIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_rom_o |-> $past(xio_i && romen));  // R5
  AST_LOCAL_LOWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_local_o |-> !offset_o[ADDR_W-1]);  // R1
endmodule

// File: tb/tb_prog_space_decoder.sv
`timescale 1ns/1ps
module tb_prog_space_decoder;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req, wr, dma, ovly, mpmc, xio, gpio0, cfg_we, drom;
  logic [6:0] page;
  logic [15:0] addr;
  logic [7:0] cfg_wd;
  logic s_none, s_loc, s_sh, s_rom, s_ext, viol, vld, romen, sram_en;
  logic [2:0] ppage;
  logic [15:0] off;

  int checks = 0, fails = 0;
  bit done = 0;

  prog_space_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req), .page_i(page), .addr_i(addr),
    .wr_i(wr), .dma_i(dma), .ovly_i(ovly), .mpmc_i(mpmc), .xio_i(xio),
    .gpio0_i(gpio0), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .drom_i(drom),
    .sel_none_o(s_none), .sel_local_o(s_loc), .sel_shared_o(s_sh), .sel_rom_o(s_rom),
    .sel_ext_o(s_ext), .phys_page_o(ppage), .offset_o(off), .viol_o(viol),
    .valid_o(vld), .romen_o(romen), .sram_en_o(sram_en)
  );

  task automatic chk(input string req_id, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h page=%0d addr=%h", req_id, act, exp, page, addr);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // sel bundle {ext,rom,shared,local,none}
  function automatic logic [5:0] model(input int pg, input int ad, input bit w, input bit d,
                                       input bit ov, input bit mp, input bit ra, output string tag);
    logic [4:0] s; bit v = 0;
    if (ad < 32768) begin tag = "R1"; s = ov ? 5'b00010 : 5'b10000; end
    else if (mp) begin tag = "R2"; s = 5'b10000; end
    else if (pg >= 4) begin tag = "R3"; s = 5'b10000; end
    else if (ra && pg == 0 && ad >= 57344) begin tag = "R5"; s = (ad >= 63488) ? 5'b01000 : 5'b00001; end
    else if (w && !d) begin tag = "R7"; s = 5'b00001; v = 1; end
    else begin tag = (w ? "R7" : "R3"); s = 5'b00100; end
    return {v, s};
  endfunction

  task automatic sweep(input bit ren);
    int addrs[8] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hDFFF, 16'hE000, 16'hF7FF, 16'hF800, 16'hFFFF};
    for (int pg = 0; pg < 128; pg++)
      for (int ai = 0; ai < 8; ai++)
        for (int m = 0; m < 32; m++) begin
          logic [5:0] e; string tag; int ep;
          req = 1; page = 7'(pg); addr = 16'(addrs[ai]);
          wr = m[0]; dma = m[1]; ovly = m[2]; mpmc = m[3]; xio = m[4];
          @(negedge clk);
          e = model(pg, addrs[ai], m[0], m[1], m[2], m[3], m[4] & ren, tag);
          chk(tag, {viol, s_ext, s_rom, s_sh, s_loc, s_none}, e);
          ep = (pg < 4) ? pg : 4 + pg % 4;
          chk("R4", {ppage, off}, (ep << 16) | addrs[ai]);
        end
    req = 0;
    @(negedge clk);
    chk("R8", {vld, s_ext, s_rom, s_sh, s_loc, s_none}, 0);
  endtask

  task automatic do_reset(input bit g);
    rst_n = 0; gpio0 = g;
    repeat (2) @(negedge clk);
    chk("R10", {s_ext, s_rom, s_sh, s_loc, s_none, viol, vld, sram_en}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R6", romen, g);
  endtask

  task automatic cfg_write(input logic [7:0] v);
    cfg_we = 1; cfg_wd = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    req = 0; wr = 0; dma = 0; ovly = 0; mpmc = 0; xio = 0; cfg_we = 0; cfg_wd = 0;
    drom = 0; page = 0; addr = 0;
    do_reset(1'b1);
    chk("R9", sram_en, 0);
    drom = 1; @(negedge clk); chk("R9", sram_en, 1);
    drom = 0; @(negedge clk); chk("R9", sram_en, 0);
    sweep(1'b1);
    cfg_write(8'h80); chk("R6", romen, 1);
    cfg_write(8'h7F); chk("R6", romen, 0);
    cfg_write(8'hFF); chk("R6", romen, 0);
    sweep(1'b0);
    do_reset(1'b0);
    cfg_write(8'h80); chk("R6", romen, 0);
    done = 1;
    finish_run();
  end

  initial begin
    #5ms;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule